// File: doc/BRIEF.md
# Multi-Speed Data-Strobe Serial Datapath

This block is the digital transmit and receive path of one serial port that runs at three line rates over a data line and a strobe line. On the transmit side the link layer hands over one parallel word per system clock. Depending on the selected speed, 2, 4 or 8 of its bits are used. The block queues the word into a fast serial-clock domain, shifts it out most significant bit first and encodes it with data-strobe coding. Under that coding exactly one of the two lines changes in every bit cell. The serial clock runs at eight times the system clock, so a bit cell lasts 4, 2 or 1 serial clocks and the three speeds give 2, 4 or 8 bits per system clock.

On the receive side the bit clock is rebuilt as the exclusive-or of the incoming data and strobe lines. One bit is taken on each edge of that clock. The bits are grouped into words whose width is set by the receive speed. Each word is written into an asynchronous FIFO clocked by the recovered clock, and the system-clock side reads it out as a one-cycle valid pulse. While the port is receiving, its own transmit enable is dropped and the incoming line pair is mirrored onto every other port that reports a live link.

Top module: `ds_link_phy`

## Requirements
- R1: Speed code 00 takes bits [1:0] of `tx_data`, code 01 takes bits [3:0] and code 10 takes bits [7:0]. The remaining upper bits of an accepted word have no effect on either line. A word is accepted on a `sys_clk` edge when `tx_valid` and `tx_ready` are both high.
- R2: `ser_clk` runs at 8 times `sys_clk`. While a word is being sent, a bit cell lasts 4, 2 or 1 `ser_clk` cycles for speed codes 00, 01 and 10.
- R3: In every bit cell exactly one of `tx_ds_data` and `tx_ds_strobe` changes. The strobe toggles when the new data bit equals the previous data bit, and the data line toggles otherwise. When no word is queued, both lines hold still.
- R4: Within a word, bit W-1 is sent first and bit 0 last, where W is the word width of the speed.
- R5: After reset, both transmit lines are low, `tx_ready` is high, `rx_valid` is low, `tx_oe` is high (with `rx_active` low) and all `rep_oe` bits are low.
- R6: Each received word is delivered on `rx_word` during a single `sys_clk` cycle with `rx_valid` high. Words arrive in order, right-justified to the width set by `rx_speed`, with the upper bits zero. At full line rate the receive FIFO never overflows.
- R7: Idle gaps of any length between words do not disturb word alignment or content on the receive side.
- R8: While `rx_active` is high, `tx_oe` is low. Each `rep_oe[i]` equals `link_up[i]`, and `rep_data[i]`/`rep_strobe[i]` copy the received line pair. Ports whose `rep_oe` bit is low hold both repeat lines low.
- R9: Speed code 11 behaves exactly like code 00, on both transmit and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the link-layer side |
| ser_clk | input | 1 | Serial clock, 8 times `sys_clk` |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| speed | input | 2 | Transmit speed code; change only while idle |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 8 | Transmit word, right-justified |
| tx_ready | output | 1 | Transmit queue can take a word |
| tx_ds_data | output | 1 | Encoded data line |
| tx_ds_strobe | output | 1 | Encoded strobe line |
| tx_oe | output | 1 | Transmit line enable |
| rx_ds_data | input | 1 | Incoming data line |
| rx_ds_strobe | input | 1 | Incoming strobe line |
| rx_speed | input | 2 | Receive speed code; change only while idle |
| rx_valid | output | 1 | Received word present this cycle |
| rx_word | output | 8 | Received word, right-justified |
| rx_active | input | 1 | Port is currently receiving |
| link_up | input | N_REP | Live-link flag of each other port |
| rep_data | output | N_REP | Repeated data line per other port |
| rep_strobe | output | N_REP | Repeated strobe line per other port |
| rep_oe | output | N_REP | Repeat enable per other port |

## Verification
Assertions check the line encoding on every serial cycle. They confirm that the two transmit lines never change together, and that during a continuous run every cell has the length the latched speed calls for. They also watch both FIFOs for writes while full and reads while empty, which is how a receive overflow at line rate would show up. Other properties can only be shown by the bench's loopback scenarios: that words come back intact and in order at every speed, the bit order inside a word, that upper input bits are masked, that idle gaps are tolerated, and how the repeat outputs behave.

// File: rtl/ds_link_pkg.sv
package ds_link_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [1:0] {
        SPD_LOW  = 2'b00,
        SPD_MID  = 2'b01,
        SPD_HIGH = 2'b10,
        SPD_RSVD = 2'b11
    } ds_speed_e;

    // Bits carried per system-clock word.
    function automatic logic [3:0] bits_per_word(input logic [1:0] spd);
        case (ds_speed_e'(spd))
            SPD_MID:  return 4'd4;
            SPD_HIGH: return 4'd8;
            default:  return 4'd2;
        endcase
    endfunction

    // Serial-clock cycles per bit cell.
    function automatic logic [2:0] cycles_per_cell(input logic [1:0] spd);
        case (ds_speed_e'(spd))
            SPD_MID:  return 3'd2;
            SPD_HIGH: return 3'd1;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ds_afifo.sv
module ds_afifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_req,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);   // DEPTH must be a power of two, at least 4

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
    } ptr_t;

    logic [W-1:0] mem [DEPTH];
    ptr_t         w_d, w_q, r_d, r_q;
    logic [AW:0]  rq1_q, rq2_q, wq1_q, wq2_q;
    logic         wr_en, rd_en;

    assign full  = (w_q.gray == {~rq2_q[AW:AW-1], rq2_q[AW-2:0]});
    assign empty = (r_q.gray == wq2_q);
    assign wr_en = wr_req && !full;
    assign rd_en = rd_req && !empty;
    assign rdata = mem[r_q.bin[AW-1:0]];

    always_comb begin
        w_d      = w_q;
        w_d.bin  = w_q.bin + (AW+1)'(wr_en);
        w_d.gray = w_d.bin ^ (w_d.bin >> 1);
        r_d      = r_q;
        r_d.bin  = r_q.bin + (AW+1)'(rd_en);
        r_d.gray = r_d.bin ^ (r_d.bin >> 1);
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            w_q   <= '0;
            rq1_q <= '0;
            rq2_q <= '0;
        end else begin
            w_q   <= w_d;
            rq1_q <= r_q.gray;
            rq2_q <= rq1_q;
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_en) mem[w_q.bin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            r_q   <= '0;
            wq1_q <= '0;
            wq2_q <= '0;
        end else begin
            r_q   <= r_d;
            wq1_q <= w_q.gray;
            wq2_q <= wq1_q;
        end
    end

    // R6: a word offered to the queue must find room
    p_no_overflow_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_req |-> !full);

    // R6: the consumer only pops a word that is present
    p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_req |-> !empty);

endmodule

// File: rtl/ds_tx_serializer.sv
module ds_tx_serializer
    import ds_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        speed,
    input  logic              q_empty,
    input  logic [WORD_W-1:0] q_word,
    output logic              q_pop,
    output logic              line_d,
    output logic              line_s
);
    typedef struct packed {
        logic              busy;
        logic [WORD_W-1:0] word;
        logic [2:0]        idx;
        logic [2:0]        div;
        logic [1:0]        spd;
        logic              d;
        logic              s;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    load, emit, nbit;
    logic [3:0] bpw_new;

    assign bpw_new = bits_per_word(speed);

    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        emit  = 1'b0;
        nbit  = 1'b0;
        q_pop = 1'b0;
        if (!st_q.busy) begin
            load = !q_empty;
        end else if (st_q.div != 3'd0) begin
            st_d.div = st_q.div - 3'd1;
        end else if (st_q.idx != 3'd0) begin
            st_d.idx = st_q.idx - 3'd1;
            nbit     = st_q.word[st_q.idx - 3'd1];
            emit     = 1'b1;
            st_d.div = cycles_per_cell(st_q.spd) - 3'd1;
        end else begin
            load = !q_empty;
            if (q_empty) st_d.busy = 1'b0;
        end
        if (load) begin
            q_pop     = 1'b1;
            st_d.busy = 1'b1;
            st_d.spd  = speed;
            st_d.word = q_word;
            st_d.idx  = 3'(bpw_new - 4'd1);
            nbit      = q_word[3'(bpw_new - 4'd1)];
            emit      = 1'b1;
            st_d.div  = cycles_per_cell(speed) - 3'd1;
        end
        if (emit) begin
            st_d.d = nbit;
            st_d.s = (nbit == st_q.d) ? ~st_q.s : st_q.s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_d = st_q.d;
    assign line_s = st_q.s;

    // Checker state: previous line levels and distance between changes
    logic       a_pd_q, a_ps_q, a_arm_q, a_chg;
    logic [3:0] a_gap_q;

    assign a_chg = (st_q.d != a_pd_q) || (st_q.s != a_ps_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_pd_q  <= 1'b0;
            a_ps_q  <= 1'b0;
            a_arm_q <= 1'b0;
            a_gap_q <= 4'd0;
        end else begin
            a_pd_q <= st_q.d;
            a_ps_q <= st_q.s;
            if (a_chg)                  a_gap_q <= 4'd1;
            else if (a_gap_q != 4'hF)   a_gap_q <= a_gap_q + 4'd1;
            if (!st_q.busy)             a_arm_q <= 1'b0;
            else if (a_chg)             a_arm_q <= 1'b1;
        end
    end

    // R3: data and strobe never change in the same cell
    p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !((st_q.d != a_pd_q) && (st_q.s != a_ps_q)));

    // R2: within a continuous run, cells have the length of the latched speed
    p_cell_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_chg && a_arm_q && st_q.busy) |-> (a_gap_q == {1'b0, cycles_per_cell(st_q.spd)}));

endmodule

// File: rtl/ds_rx_deserializer.sv
module ds_rx_deserializer
    import ds_link_pkg::*;
(
    input  logic              rst_n,
    input  logic              line_d,
    input  logic              line_s,
    input  logic [1:0]        speed,
    output logic              wr_clk,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_word
);
    typedef struct packed {
        logic [WORD_W-3:0] sh;
        logic [1:0]        cnt;
    } des_st_t;

    des_st_t st_d, st_q;
    logic    bclk, first_q, last;
    logic [1:0] pairs_m1;

    // Recovered bit clock: toggles once per cell
    assign bclk   = line_d ^ line_s;
    assign wr_clk = ~bclk;

    // Odd cells raise bclk: hold that bit until the even cell completes the pair
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= line_d;
    end

    assign pairs_m1 = 2'((bits_per_word(speed) >> 1) - 4'd1);
    assign last     = (st_q.cnt == pairs_m1);

    always_comb begin
        st_d    = st_q;
        wr_req  = 1'b0;
        wr_word = {st_q.sh, first_q, line_d};
        if (last) begin
            wr_req   = 1'b1;
            st_d.sh  = '0;
            st_d.cnt = 2'd0;
        end else begin
            st_d.sh  = {st_q.sh[WORD_W-5:0], first_q, line_d};
            st_d.cnt = st_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the shift register is empty whenever a new word starts
    p_word_clean_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (st_q.cnt == 2'd0) |-> (st_q.sh == '0));

endmodule

// File: rtl/ds_link_phy.sv
module ds_link_phy
    import ds_link_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 16,
    parameter int N_REP    = 3
) (
    input  logic              sys_clk,
    input  logic              ser_clk,
    input  logic              rst_n,
    input  logic [1:0]        speed,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              tx_ds_data,
    output logic              tx_ds_strobe,
    output logic              tx_oe,
    input  logic              rx_ds_data,
    input  logic              rx_ds_strobe,
    input  logic [1:0]        rx_speed,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word,
    input  logic              rx_active,
    input  logic [N_REP-1:0]  link_up,
    output logic [N_REP-1:0]  rep_data,
    output logic [N_REP-1:0]  rep_strobe,
    output logic [N_REP-1:0]  rep_oe
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } rx_out_t;

    logic              txq_full, txq_empty, txq_pop;
    logic [WORD_W-1:0] txq_word;
    logic              rxq_wclk, rxq_wreq, rxq_full, rxq_empty;
    logic [WORD_W-1:0] rxq_wword, rxq_rword;
    rx_out_t           ro_d, ro_q;

    assign tx_ready = !txq_full;

    ds_afifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
        .wclk(sys_clk), .wrst_n(rst_n), .wr_req(tx_valid && tx_ready),
        .wdata(tx_data), .full(txq_full),
        .rclk(ser_clk), .rrst_n(rst_n), .rd_req(txq_pop),
        .rdata(txq_word), .empty(txq_empty)
    );

    ds_tx_serializer u_ser (
        .clk(ser_clk), .rst_n(rst_n), .speed(speed),
        .q_empty(txq_empty), .q_word(txq_word), .q_pop(txq_pop),
        .line_d(tx_ds_data), .line_s(tx_ds_strobe)
    );

    ds_rx_deserializer u_des (
        .rst_n(rst_n), .line_d(rx_ds_data), .line_s(rx_ds_strobe),
        .speed(rx_speed), .wr_clk(rxq_wclk), .wr_req(rxq_wreq), .wr_word(rxq_wword)
    );

    ds_afifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
        .wclk(rxq_wclk), .wrst_n(rst_n), .wr_req(rxq_wreq),
        .wdata(rxq_wword), .full(rxq_full),
        .rclk(sys_clk), .rrst_n(rst_n), .rd_req(!rxq_empty),
        .rdata(rxq_rword), .empty(rxq_empty)
    );

    always_comb begin
        ro_d.vld  = !rxq_empty;
        ro_d.word = rxq_empty ? ro_q.word : rxq_rword;
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) ro_q <= '0;
        else        ro_q <= ro_d;
    end

    assign rx_valid = ro_q.vld;
    assign rx_word  = ro_q.word;
    assign tx_oe    = !rx_active;

    for (genvar i = 0; i < N_REP; i++) begin : g_rep
        always_comb begin
            rep_oe[i]     = rx_active && link_up[i];
            rep_data[i]   = rep_oe[i] && rx_ds_data;
            rep_strobe[i] = rep_oe[i] && rx_ds_strobe;
        end
    end

    // R6: a delivered word never has bits set above the receive width
    p_rx_width_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
        rx_valid |-> ((rx_word >> bits_per_word(rx_speed)) == '0));

    // R8: the own transmitter and the repeaters are never enabled together
    p_no_echo_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (rep_oe != '0) |-> !tx_oe);

endmodule

// File: tb/sim_ds_link_phy.sv
`timescale 1ns/1ps
module sim_ds_link_phy;
    logic       sys_clk = 1'b0, ser_clk = 1'b0, rst_n = 1'b0;
    logic [1:0] speed = 2'b00, rx_speed = 2'b00;
    logic       tx_valid = 1'b0, tx_ready, tx_ds_data, tx_ds_strobe, tx_oe;
    logic [7:0] tx_data = 8'h00, rx_word;
    logic       rx_valid, rx_active = 1'b0;
    logic [2:0] link_up = 3'b000, rep_data, rep_strobe, rep_oe;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [7:0] rxq[$];
    logic [7:0] expq[$];

    always #5 sys_clk = ~sys_clk;
    always #0.625 ser_clk = ~ser_clk;

    ds_link_phy u0 (
        .sys_clk(sys_clk), .ser_clk(ser_clk), .rst_n(rst_n), .speed(speed),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_ds_data(tx_ds_data), .tx_ds_strobe(tx_ds_strobe), .tx_oe(tx_oe),
        .rx_ds_data(tx_ds_data), .rx_ds_strobe(tx_ds_strobe), .rx_speed(rx_speed),
        .rx_valid(rx_valid), .rx_word(rx_word), .rx_active(rx_active),
        .link_up(link_up), .rep_data(rep_data), .rep_strobe(rep_strobe), .rep_oe(rep_oe)
    );

    always @(negedge sys_clk) if (rst_n && rx_valid) rxq.push_back(rx_word);

    function automatic int width_of(input logic [1:0] s);
        return (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 2;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_speed(input logic [1:0] s);
        repeat (40) @(negedge sys_clk);
        speed = s; rx_speed = s;
        repeat (2) @(negedge sys_clk);
        rxq.delete(); expq.delete();
    endtask

    task automatic send_word(input logic [7:0] w);
        @(negedge sys_clk);
        while (!tx_ready) @(negedge sys_clk);
        tx_valid = 1'b1; tx_data = w;
        expq.push_back(w & 8'((1 << width_of(speed)) - 1));
        @(negedge sys_clk);
        tx_valid = 1'b0;
    endtask

    task automatic compare_rx(input string req);
        int bad = 0;
        repeat (60) @(negedge sys_clk);
        check(rxq.size() == expq.size(), req, "word count", rxq.size(), expq.size());
        foreach (expq[i]) if (i < rxq.size() && rxq[i] !== expq[i]) begin
            bad++;
            $display("FAIL %s word %0d: got %0h expected %0h", req, i, rxq[i], expq[i]);
        end
        tests++;
        if (bad != 0) fails++;
        rxq.delete(); expq.delete();
    endtask

    // R5: levels right after reset
    task automatic t_reset;
        check(tx_ds_data == 0 && tx_ds_strobe == 0, "R5", "lines", {tx_ds_data, tx_ds_strobe}, 0);
        check(tx_ready == 1, "R5", "tx_ready", tx_ready, 1);
        check(rx_valid == 0, "R5", "rx_valid", rx_valid, 0);
        check(tx_oe == 1 && rep_oe == 0, "R5", "enables", {tx_oe, rep_oe}, 8);
    endtask

    // R2 R3 R4: waveform of one isolated word
    task automatic t_shape(input logic [1:0] s, input logic [7:0] w);
        int w_bits, cpb, ntr, last_cyc, bad_len, bad_both, bad_bit;
        logic pd, ps;
        set_speed(s);
        w_bits = width_of(s);
        cpb = 8 / w_bits;
        ntr = 0; last_cyc = 0; bad_len = 0; bad_both = 0; bad_bit = 0;
        @(negedge ser_clk);
        pd = tx_ds_data; ps = tx_ds_strobe;
        fork
            send_word(w);
            for (int c = 1; c <= 200; c++) begin
                @(negedge ser_clk);
                if (tx_ds_data != pd || tx_ds_strobe != ps) begin
                    ntr++;
                    if (tx_ds_data != pd && tx_ds_strobe != ps) bad_both++;
                    if (ntr > 1 && c - last_cyc != cpb) bad_len++;
                    if (ntr <= w_bits && tx_ds_data != w[w_bits - ntr]) bad_bit++;
                    if ((tx_ds_data == pd) != (tx_ds_strobe != ps)) bad_both++;
                    last_cyc = c;
                end
                pd = tx_ds_data; ps = tx_ds_strobe;
            end
        join
        check(ntr == w_bits, "R3", "cell count", ntr, w_bits);
        check(bad_both == 0, "R3", "double change", bad_both, 0);
        check(bad_len == 0, "R2", "cell length", bad_len, 0);
        check(bad_bit == 0, "R4", "msb-first order", bad_bit, 0);
        compare_rx("R6");
    endtask

    // R1 R6: back-to-back random words
    task automatic t_stream(input logic [1:0] s, input int n, input string req);
        set_speed(s);
        @(negedge sys_clk);
        for (int i = 0; i < n; i++) begin
            while (!tx_ready) @(negedge sys_clk);
            tx_valid = 1'b1; tx_data = 8'($urandom);
            expq.push_back(tx_data & 8'((1 << width_of(s)) - 1));
            @(negedge sys_clk);
        end
        tx_valid = 1'b0;
        compare_rx(req);
    endtask

    // R7: idle gaps of varying length between words
    task automatic t_gaps(input logic [1:0] s);
        set_speed(s);
        for (int i = 0; i < 20; i++) begin
            send_word(8'($urandom));
            repeat (i % 5) @(negedge sys_clk);
        end
        compare_rx("R7");
    endtask

    // R8: repeat outputs while receiving
    task automatic t_repeat;
        int bad = 0;
        set_speed(2'b10);
        rx_active = 1'b1; link_up = 3'b101;
        @(negedge sys_clk);
        check(tx_oe == 0, "R8", "tx_oe", tx_oe, 0);
        check(rep_oe == 3'b101, "R8", "rep_oe", rep_oe, 3'b101);
        fork
            for (int i = 0; i < 6; i++) send_word(8'($urandom));
            for (int c = 0; c < 150; c++) begin
                @(negedge ser_clk);
                if (rep_data[0] != tx_ds_data || rep_strobe[0] != tx_ds_strobe) bad++;
                if (rep_data[2] != tx_ds_data || rep_strobe[2] != tx_ds_strobe) bad++;
                if (rep_data[1] || rep_strobe[1]) bad++;
            end
        join
        check(bad == 0, "R8", "repeat lines", bad, 0);
        compare_rx("R8");
        rx_active = 1'b0; link_up = 3'b000;
        @(negedge sys_clk);
        check(tx_oe == 1 && rep_oe == 0, "R8", "enables after", {tx_oe, rep_oe}, 8);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge sys_clk);
        rst_n = 1'b1;
        @(negedge sys_clk);
        t_reset();
        t_shape(2'b00, 8'h02);
        t_shape(2'b01, 8'h0B);
        t_shape(2'b10, 8'hB4);
        t_shape(2'b10, 8'h00);
        t_stream(2'b00, 40, "R1");
        t_stream(2'b01, 40, "R6");
        t_stream(2'b10, 60, "R6");
        t_stream(2'b11, 30, "R9");
        t_shape(2'b11, 8'hFD);
        t_gaps(2'b00);
        t_gaps(2'b10);
        t_repeat();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule